// File: doc/BRIEF.md
# Two-Part Interframe Deferral Timer

This block sits on the transmit side of a 10 Mbps CSMA/CD MAC. It decides the moment at which a queued frame may go onto the medium. The block watches carrier sense and the MAC's own transmitting flag. Once both are quiet, it counts the interframe gap in bit times. The bit-time clock enable paces the count. When the count reaches the programmed gap and a frame is waiting, the block raises a transmit-permitted signal. The same gap is used after a received frame and after one of the block's own frames.

The gap has two parts. In the early part the station still defers: carrier appearing there sends the timer back to zero. In the late part carrier is ignored, and a waiting frame is released at the full count even if it then collides. This keeps a station from being held off forever by a neighbour that shrinks the gap. A disable input turns the split off, and every carrier event inside the gap then restarts it. A phase output shows which part of the deferral is running. Typical settings are a 96-bit gap with a 60-bit first part.

Top module: `ifg_defer`

## Requirements
- R1: While reset is held and in the first cycle after it, `phase` is 0 (medium busy) and `tx_go` is 0. The phase codes are 0 = busy/hold, 1 = first part (resettable), 2 = second part (carrier ignored) and 3 = gap complete.
- R2: The block stays in phase 0 as long as `crs` or `tx_active` is high. Gap timing starts, from zero, on the first clock edge at which both are low.
- R3: The count advances only on edges where `bit_en` is high. With `bit_en` held high, phase 3 is entered G edges after the edge that started the gap, where G is the gap length.
- R4: If `crs` is high on an edge while in phase 1, the block returns to phase 0 with the count at zero. A full gap is then timed again once carrier drops.
- R5: In phase 2, `crs` has no effect. The gap completes at the full count, and a pending frame is permitted even while carrier is present.
- R6: When `two_part_off` is 1, the first-part length is ignored and the whole gap behaves as phase 1, so carrier at any point before completion restarts the gap.
- R7: A first-part length greater than or equal to the gap makes the whole gap resettable. A first-part length of 0 starts the gap directly in phase 2.
- R8: `gap_len`, `part1_len` and `two_part_off` are captured when a gap starts. Changes made during a gap take effect only at the next one.
- R9: `tx_go` is high exactly while `phase` is 3, `tx_req` is high and `tx_active` is low. `tx_active` high on an edge sends the block to phase 0.
- R10: In phase 3 with no frame pending, carrier on an edge returns the block to phase 0. With a frame pending, phase 3 is held until transmission starts.
- R11: A gap length of 0 is treated as 1.
- R12: The gap count never exceeds the captured gap length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One pulse per bit time |
| crs | input | 1 | Carrier sense |
| tx_active | input | 1 | The MAC is transmitting |
| tx_req | input | 1 | A frame is waiting to transmit |
| gap_len | input | CW | Total interframe gap, in bit times |
| part1_len | input | CW | Resettable first-part length, in bit times |
| two_part_off | input | 1 | 1 = single-part deference |
| tx_go | output | 1 | Transmission permitted |
| phase | output | 2 | Deferral phase (see R1) |

## Verification
The assertions check the phase moves on every cycle:
- busy holds phase 0;
- carrier in the first part drops back to phase 0;
- the second part survives carrier and stalls without `bit_en`;
- transmission forces phase 0;
- the count stays within the captured gap.

The bench scenarios are needed to show the exact gap length in clocks. They also cover the boundary between the two parts, the clamping of the first-part length, and the capture of settings at the start of a gap. These are timing facts that span tens of cycles, and only the measured grant edge can show them.

// File: rtl/ifg_defer.sv
module ifg_defer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          crs,
  input  logic          tx_active,
  input  logic          tx_req,
  input  logic [CW-1:0] gap_len,
  input  logic [CW-1:0] part1_len,
  input  logic          two_part_off,
  output logic          tx_go,
  output logic [1:0]    phase
);

  localparam logic [1:0] PH_HOLD = 2'd0;
  localparam logic [1:0] PH_P1   = 2'd1;
  localparam logic [1:0] PH_P2   = 2'd2;
  localparam logic [1:0] PH_DONE = 2'd3;

  logic [1:0]    phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d, gap_q, gap_d, p1_q, p1_d;
  logic [CW-1:0] gap_eff, p1_eff, cnt_inc;
  logic          idle;

  assign idle    = !crs && !tx_active;
  assign gap_eff = (gap_len == '0) ? CW'(1) : gap_len;
  assign p1_eff  = (two_part_off || part1_len >= gap_eff) ? gap_eff : part1_len;
  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    gap_d   = gap_q;
    p1_d    = p1_q;
    case (phase_q)
      PH_HOLD: begin
        if (idle) begin
          cnt_d   = '0;
          gap_d   = gap_eff;
          p1_d    = p1_eff;
          phase_d = (p1_eff == '0) ? PH_P2 : PH_P1;
        end
      end
      PH_P1: begin
        if (!idle) begin
          phase_d = PH_HOLD;
          cnt_d   = '0;
        end else if (bit_en) begin
          cnt_d = cnt_inc;
          if (cnt_inc >= gap_q)     phase_d = PH_DONE;
          else if (cnt_inc >= p1_q) phase_d = PH_P2;
        end
      end
      PH_P2: begin
        if (tx_active) begin
          phase_d = PH_HOLD;
          cnt_d   = '0;
        end else if (bit_en) begin
          cnt_d = cnt_inc;
          if (cnt_inc >= gap_q) phase_d = PH_DONE;
        end
      end
      default: begin
        if (tx_active || (crs && !tx_req)) begin
          phase_d = PH_HOLD;
          cnt_d   = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_HOLD;
      cnt_q   <= '0;
      gap_q   <= '0;
      p1_q    <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      gap_q   <= gap_d;
      p1_q    <= p1_d;
    end
  end

  assign tx_go = (phase_q == PH_DONE) && tx_req && !tx_active;
  assign phase = phase_q;

endmodule

// File: rtl/ifg_defer_chk.sv
module ifg_defer_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic          crs,
  input logic          tx_active,
  input logic          tx_req,
  input logic          tx_go,
  input logic [1:0]    phase,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] gap_cap
);

  a_r1_reset_hold: assert property (@(posedge clk)
    !rst_n |=> (phase == 2'd0 && !tx_go));

  a_r2_busy_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0 && (crs || tx_active)) |=> phase == 2'd0);

  a_r3_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == 2'd1 || phase == 2'd2) && !bit_en && !crs && !tx_active) |=> $stable(cnt));

  a_r4_part1_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd1 && crs) |=> (phase == 2'd0 && cnt == '0));

  a_r5_part2_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2 && !tx_active) |=> (phase == 2'd2 || phase == 2'd3));

  a_r9_tx_resets: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |=> phase == 2'd0);

  a_r9_go_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |-> (tx_req && !tx_active));

  a_r10_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3 && tx_req && !tx_active) |=> phase == 2'd3);

  a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 2'd0) |-> cnt <= gap_cap);

endmodule

bind ifg_defer ifg_defer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .crs(crs), .tx_active(tx_active),
  .tx_req(tx_req), .tx_go(tx_go), .phase(phase), .cnt(cnt_q), .gap_cap(gap_q)
);

// File: tb/ifg_defer_tb.sv
module ifg_defer_tb;
  localparam int CW = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic bit_en = 1;
  logic crs = 1;
  logic tx_active = 0;
  logic tx_req = 0;
  logic [CW-1:0] gap_len = 8'd12;
  logic [CW-1:0] part1_len = 8'd8;
  logic two_part_off = 0;
  logic tx_go;
  logic [1:0] phase;

  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  ifg_defer #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .crs(crs), .tx_active(tx_active),
    .tx_req(tx_req), .gap_len(gap_len), .part1_len(part1_len),
    .two_part_off(two_part_off), .tx_go(tx_go), .phase(phase)
  );

  // gap, part1, off, carrier pulse after check m (0 = none), expected grant check n
  localparam int VEC[12][5] = '{
    '{12,  8, 0,  0,  13},  // R3 clean gap
    '{12,  8, 0,  3,  17},  // R4 early carrier restarts
    '{12,  8, 0, 10,  13},  // R5 late carrier ignored
    '{12,  8, 1, 10,  24},  // R6 disabled: late carrier restarts
    '{12, 20, 0, 10,  24},  // R7 part1 >= gap
    '{12,  8, 0,  8,  22},  // R4 last first-part bit
    '{12,  8, 0,  9,  13},  // R5 first second-part bit
    '{96, 60, 0,  0,  97},  // R3 default lengths
    '{96, 60, 0, 61,  97},  // R5 default, late carrier
    '{96, 60, 0, 60, 158},  // R4 default, last first-part bit
    '{ 5,  0, 0,  2,   6},  // R7 part1 zero: all second part
    '{ 0,  8, 0,  0,   2}   // R11 gap zero as one
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_gap(input int g, input int p, input int off, input int m, input int len,
                         input int st, input int sl, input int chg, output int n);
    @(negedge clk);
    tx_req = 0; tx_active = 0; crs = 1; bit_en = 1;
    gap_len = CW'(g); part1_len = CW'(p); two_part_off = off[0];
    repeat (2) @(negedge clk);
    tx_req = 1;
    @(negedge clk);
    crs = 0;
    n = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      n++;
      if (tx_go) break;
      if (n == m) crs = 1;
      if (n == m + len) crs = 0;
      if (n == st) bit_en = 0;
      if (n == st + sl) bit_en = 1;
      if (n == chg) begin gap_len = 8'd100; part1_len = 8'd90; end
    end
    crs = 0; bit_en = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    nchk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int n;
    // R1 reset
    repeat (3) @(negedge clk);
    chk(phase == 2'd0, "R1 phase in reset", phase, 0);
    chk(!tx_go, "R1 tx_go in reset", tx_go, 0);
    rst_n = 1;
    @(negedge clk);
    chk(phase == 2'd0, "R1 phase after reset", phase, 0);

    for (int i = 0; i < 12; i++) begin
      run_gap(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 1, 0, 0, 0, n);
      chk(n == VEC[i][4], $sformatf("R3/R4/R5/R6/R7/R11 vector %0d grant", i), n, VEC[i][4]);
      chk(phase == 2'd3, $sformatf("R9 vector %0d phase at grant", i), phase, 3);
    end

    // R9 tx_go drops with tx_active; R2 own transmission holds
    tx_active = 1;
    #1;
    chk(!tx_go, "R9 tx_go during transmit", tx_go, 0);
    @(negedge clk);
    chk(phase == 2'd0, "R9 phase after transmit start", phase, 0);
    tx_req = 0;
    repeat (3) @(negedge clk);
    chk(phase == 2'd0, "R2 hold while transmitting", phase, 0);
    tx_active = 0; crs = 1;
    repeat (3) @(negedge clk);
    chk(phase == 2'd0, "R2 hold while carrier", phase, 0);

    // R3 stall: bit_en low for 40 cycles
    run_gap(12, 8, 0, 0, 0, 3, 40, 0, n);
    chk(n == 53, "R3 bit_en stall grant", n, 53);

    // R8 change during gap ignored
    run_gap(12, 8, 0, 0, 0, 0, 0, 1, n);
    chk(n == 13, "R8 settings captured", n, 13);
    // R8 new settings used for next gap (100, part1 90 still applied)
    run_gap(100, 90, 0, 0, 0, 0, 0, 0, n);
    chk(n == 101, "R8 next gap length", n, 101);

    // R5 carrier held from second part through grant
    run_gap(12, 8, 0, 10, 1000, 0, 0, 0, n);
    chk(n == 13, "R5 grant with carrier", n, 13);
    crs = 1;
    @(negedge clk);
    chk(phase == 2'd3 && tx_go, "R10 pending held under carrier", phase, 3);

    // R9 no grant without request; R10 idle carrier returns to hold
    crs = 0; tx_req = 0;
    @(negedge clk);
    chk(phase == 2'd3 && !tx_go, "R9 no go without request", tx_go, 0);
    tx_req = 1;
    #1;
    chk(tx_go, "R9 go with request", tx_go, 1);
    tx_req = 0; crs = 1;
    @(negedge clk);
    chk(phase == 2'd0, "R10 carrier with nothing pending", phase, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule